// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the condition flags of a serial port's receive and transmit queues and turns them into one level-sensitive interrupt. The queue fill levels come in as counts. Each cycle the block compares them with two programmable thresholds and with the empty and full limits, which produces a live status word. The live flags, together with single-cycle error and event pulses from the rest of the port, accumulate in a sticky event register. Software clears that register by writing ones to the bits it wants to clear.

An interrupt-enable mask is never written as a whole. One address only sets mask bits and another only clears them, so two software agents can change their own bits without a read-modify-write race. The interrupt output is high while any enabled sticky bit is set. Access is over a simple word-addressed register bus: address, write strobe and write data in, with a combinational read-data path. The block holds only control and status and has no streaming interface, so it needs no handshake.

Top module: `uisc_top`

## Requirements
- R1: Live status word (address 0, read-only) receive side: bit0 is set when rx_level >= the receive threshold, bit1 when rx_level == 0, bit2 when rx_level == FIFO_DEPTH; it reflects the current inputs with no register delay.
- R2: Live status transmit side: bit3 is set when tx_level == 0, bit4 when tx_level == FIFO_DEPTH, bit13 when tx_level >= the transmit threshold; all other live bits read zero.
- R3: At every clock edge, live bits [4:0] are ORed into the same positions of the sticky event register (address 1), and live bit13 sets sticky bit10.
- R4: A one-cycle pulse on an event input sets its sticky bit at the next edge: receive overrun bit5, framing bit6, parity bit7, receive timeout bit8, modem status bit9, transmit overflow bit12.
- R5: A write to address 1 clears each sticky bit written as one and leaves bits written as zero unchanged.
- R6: When a clearing write and a new set of the same sticky bit fall in the same cycle, the bit ends up set.
- R7: A write to address 3 ORs the written bits [12:0] into the interrupt mask.
- R8: A write to address 4 clears the written bits from the interrupt mask.
- R9: The mask reads back at address 2. Writes to address 2 and to address 0 change nothing. Reads of addresses 3 and 4 return zero.
- R10: irq is high exactly when the bitwise AND of the mask and the sticky event register is nonzero.
- R11: While reset is held, the mask and the sticky register read zero and both thresholds read 32.
- R12: The receive threshold (address 5) and the transmit threshold (address 6) are writable, read back, and take effect on the live comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_level | input | 7 | Receive queue fill count |
| tx_level | input | 7 | Transmit queue fill count |
| evt_rx_overrun | input | 1 | Receive overrun pulse |
| evt_frame_err | input | 1 | Framing error pulse |
| evt_parity_err | input | 1 | Parity error pulse |
| evt_rx_timeout | input | 1 | Receive timeout pulse |
| evt_modem | input | 1 | Modem status change pulse |
| evt_tx_overflow | input | 1 | Transmit overflow pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The live word is swept over every pair of receive and transmit fill counts from zero to full, under several threshold pairs: a threshold of zero, a threshold equal to the depth, and odd mid values. This separates an off-by-one compare from the empty and full tests. The sticky path is tried with single-count excursions, which show one-cycle capture and the bit13-to-bit10 move, and with each event pulse alone, which catches swapped positions. A partial clearing write tells per-bit clearing from a whole-register wipe, and a clear that collides with a pulse shows set priority. Mask set and clear sequences interleaved with masked and unmasked events show that irq follows only the enabled bits.

// File: rtl/uisc_pkg.sv
package uisc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int LIVE_W  = 14;
  localparam int EVT_W   = 13;
  localparam int TRIG_RST = 32;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_LIVE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVT    = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd2;
  localparam logic [ADDR_W-1:0] A_MSET   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCLR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXTRIG = 4'd5;
  localparam logic [ADDR_W-1:0] A_TXTRIG = 4'd6;

  // live status bit positions
  localparam int L_RX_TRIG  = 0;
  localparam int L_RX_EMPTY = 1;
  localparam int L_RX_FULL  = 2;
  localparam int L_TX_EMPTY = 3;
  localparam int L_TX_FULL  = 4;
  localparam int L_TX_TRIG  = 13;

  // sticky event bit positions
  localparam int E_RX_OVR   = 5;
  localparam int E_FRAME    = 6;
  localparam int E_PARITY   = 7;
  localparam int E_TIMEOUT  = 8;
  localparam int E_MODEM    = 9;
  localparam int E_TX_TRIG  = 10;
  localparam int E_TX_OVF   = 12;
  localparam int N_PULSE    = 6;

  typedef struct packed {
    logic rx_ovr;
    logic frame;
    logic parity;
    logic timeout;
    logic modem;
    logic tx_ovf;
  } evt_pulse_t;
endpackage

// File: rtl/uisc_live.sv
module uisc_live
  import uisc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_thr,
  input  logic [CNT_W-1:0]  tx_thr,
  output logic [LIVE_W-1:0] live
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    live             = '0;
    live[L_RX_TRIG]  = (rx_level >= rx_thr);
    live[L_RX_EMPTY] = (rx_level == '0);
    live[L_RX_FULL]  = (rx_level == FULL_CNT);
    live[L_TX_EMPTY] = (tx_level == '0);
    live[L_TX_FULL]  = (tx_level == FULL_CNT);
    live[L_TX_TRIG]  = (tx_level >= tx_thr);
  end
endmodule

// File: rtl/uisc_thresh.sv
module uisc_thresh
  import uisc_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int N_THR = 2,
  parameter int RST_VAL = TRIG_RST
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_THR-1:0]      wr_sel,
  input  logic [CNT_W-1:0]      wdata,
  output logic [N_THR*CNT_W-1:0] thr
);
  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= CNT_W'(RST_VAL);
      else if (wr_sel[g])  q <= wdata;
    end
    assign thr[g*CNT_W +: CNT_W] = q;
  end
endmodule

// File: rtl/uisc_mask.sv
module uisc_mask
  import uisc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_wr) mask_q <= mask_q | wdata;
    else if (clr_wr) mask_q <= mask_q & ~wdata;
  end
endmodule

// File: rtl/uisc_sticky.sv
module uisc_sticky
  import uisc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [EVT_W-1:0] clr_bits,
  output logic [EVT_W-1:0] sticky_q
);
  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           sticky_q[b] <= 1'b0;
      else if (set_vec[b])  sticky_q[b] <= 1'b1;   // set wins
      else if (clr_wr && clr_bits[b]) sticky_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/uisc_top.sv
module uisc_top
  import uisc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic              evt_rx_overrun,
  input  logic              evt_frame_err,
  input  logic              evt_parity_err,
  input  logic              evt_rx_timeout,
  input  logic              evt_modem,
  input  logic              evt_tx_overflow,
  output logic              irq
);
  localparam int N_THR = 2;

  logic [LIVE_W-1:0]      live;
  logic [EVT_W-1:0]       mask_q;
  logic [EVT_W-1:0]       sticky_q;
  logic [EVT_W-1:0]       set_vec;
  logic [N_THR*CNT_W-1:0] thr;
  logic [CNT_W-1:0]       rx_thr;
  logic [CNT_W-1:0]       tx_thr;
  logic [N_THR-1:0]       thr_wr;
  evt_pulse_t             pulses;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:EVT_W];

  assign thr_wr[0] = bus_wr && (bus_addr == A_RXTRIG);
  assign thr_wr[1] = bus_wr && (bus_addr == A_TXTRIG);
  assign rx_thr = thr[0 +: CNT_W];
  assign tx_thr = thr[CNT_W +: CNT_W];

  uisc_thresh #(.CNT_W(CNT_W), .N_THR(N_THR), .RST_VAL(TRIG_RST)) u_thresh (
    .clk(clk), .rst_n(rst_n), .wr_sel(thr_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .thr(thr)
  );

  uisc_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .live(live)
  );

  assign pulses = '{rx_ovr: evt_rx_overrun, frame: evt_frame_err,
                    parity: evt_parity_err, timeout: evt_rx_timeout,
                    modem: evt_modem, tx_ovf: evt_tx_overflow};

  always_comb begin
    set_vec            = '0;
    set_vec[4:0]       = live[4:0];
    set_vec[E_TX_TRIG] = live[L_TX_TRIG];
    set_vec[E_RX_OVR]  = pulses.rx_ovr;
    set_vec[E_FRAME]   = pulses.frame;
    set_vec[E_PARITY]  = pulses.parity;
    set_vec[E_TIMEOUT] = pulses.timeout;
    set_vec[E_MODEM]   = pulses.modem;
    set_vec[E_TX_OVF]  = pulses.tx_ovf;
  end

  uisc_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(bus_wr && (bus_addr == A_EVT)),
    .clr_bits(bus_wdata[EVT_W-1:0]), .sticky_q(sticky_q)
  );

  uisc_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_wr(bus_wr && (bus_addr == A_MSET)),
    .clr_wr(bus_wr && (bus_addr == A_MCLR)),
    .wdata(bus_wdata[EVT_W-1:0]), .mask_q(mask_q)
  );

  assign irq = |(mask_q & sticky_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LIVE:   bus_rdata = DATA_W'(live);
      A_EVT:    bus_rdata = DATA_W'(sticky_q);
      A_MASK:   bus_rdata = DATA_W'(mask_q);
      A_RXTRIG: bus_rdata = DATA_W'(rx_thr);
      A_TXTRIG: bus_rdata = DATA_W'(tx_thr);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uisc_chk.sv
module uisc_chk
  import uisc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  rx_level,
  input logic              evt_rx_overrun,
  input logic              evt_rx_timeout,
  input logic [EVT_W-1:0]  mask_q,
  input logic [EVT_W-1:0]  sticky_q,
  input logic              irq
);
  assert_rx_empty_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> sticky_q[L_RX_EMPTY]);

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_overrun |=> sticky_q[E_RX_OVR]);

  assert_no_fall_without_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_EVT) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rx_timeout && bus_wr && bus_addr == A_EVT && bus_wdata[E_TIMEOUT])
      |=> sticky_q[E_TIMEOUT]);

  assert_mask_moves_only_on_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=> $stable(mask_q));

  assert_mask_direct_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> $stable(mask_q));

  assert_irq_needs_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && sticky_q != '0));
endmodule

bind uisc_top uisc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .rx_level(rx_level),
  .evt_rx_overrun(evt_rx_overrun), .evt_rx_timeout(evt_rx_timeout),
  .mask_q(mask_q), .sticky_q(sticky_q), .irq(irq)
);

// File: tb/uisc_top_tb.sv
module uisc_top_tb;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [CW-1:0] rx_level = 10, tx_level = 10;
  logic ev_ovr = 0, ev_frm = 0, ev_par = 0, ev_to = 0, ev_mdm = 0, ev_tovf = 0;
  logic irq;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  uisc_top #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_level(rx_level), .tx_level(tx_level),
    .evt_rx_overrun(ev_ovr), .evt_frame_err(ev_frm), .evt_parity_err(ev_par),
    .evt_rx_timeout(ev_to), .evt_modem(ev_mdm), .evt_tx_overflow(ev_tovf),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    case (idx)
      0: ev_ovr = 1; 1: ev_frm = 1; 2: ev_par = 1;
      3: ev_to = 1;  4: ev_mdm = 1; default: ev_tovf = 1;
    endcase
    @(negedge clk);
    {ev_ovr, ev_frm, ev_par, ev_to, ev_mdm, ev_tovf} = '0;
  endtask

  function automatic logic [31:0] exp_live(int r, int t, int rt, int tt);
    logic [31:0] v = 0;
    v[0] = (r >= rt); v[1] = (r == 0); v[2] = (r == DEPTH);
    v[3] = (t == 0);  v[4] = (t == DEPTH); v[13] = (t >= tt);
    return v;
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 1, 0);
    finish_run();
  end

  initial begin
    int pos [6] = '{5, 6, 7, 8, 9, 12};
    int rts [4] = '{32, 0, 64, 17};
    int tts [4] = '{32, 64, 0, 41};
    // R11: reset state
    repeat (3) @(negedge clk);
    rd_chk("R11 mask", 4'd2, 0);
    rd_chk("R11 sticky", 4'd1, 0);
    rd_chk("R11 rx thr", 4'd5, 32);
    rd_chk("R11 tx thr", 4'd6, 32);
    chk("R11 irq", {31'd0, irq}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd_chk("R3 quiet levels leave sticky clear", 4'd1, 0);

    // R1 R2 R12: full sweep of both levels under several threshold pairs
    for (int k = 0; k < 4; k++) begin
      wr(4'd5, rts[k]);
      wr(4'd6, tts[k]);
      @(negedge clk);
      rd_chk("R12 rx thr readback", 4'd5, rts[k]);
      rd_chk("R12 tx thr readback", 4'd6, tts[k]);
      for (int r = 0; r <= DEPTH; r++) begin
        for (int t = 0; t <= DEPTH; t++) begin
          @(negedge clk);
          rx_level = CW'(r); tx_level = CW'(t);
          rd_chk("R1 R2 live word", 4'd0, exp_live(r, t, rts[k], tts[k]));
        end
      end
    end
    wr(4'd5, 32); wr(4'd6, 32);
    rx_level = 10; tx_level = 10;
    wr(4'd1, 32'h1FFF);
    @(negedge clk);
    rd_chk("R5 clear all", 4'd1, 0);

    // R3: single-cycle excursions
    @(negedge clk); rx_level = 0;
    @(negedge clk); rx_level = 10;
    rd_chk("R3 rx empty captured", 4'd1, 32'h002);
    wr(4'd1, 32'h1FFF);
    @(negedge clk); tx_level = 64;
    @(negedge clk); tx_level = 10;
    rd_chk("R3 tx full and trig to bit10", 4'd1, 32'h410);
    @(negedge clk); rx_level = 64;
    @(negedge clk); rx_level = 10;
    rd_chk("R3 rx full and trig", 4'd1, 32'h415);
    wr(4'd1, 32'h1FFF);

    // R4: each event alone
    for (int i = 0; i < 6; i++) begin
      pulse(i);
      rd_chk("R4 event position", 4'd1, 32'h1 << pos[i]);
      wr(4'd1, 32'h1FFF);
    end

    // R5: partial clear
    @(negedge clk);
    {ev_ovr, ev_frm, ev_par, ev_to, ev_mdm, ev_tovf} = '1;
    @(negedge clk);
    {ev_ovr, ev_frm, ev_par, ev_to, ev_mdm, ev_tovf} = '0;
    rd_chk("R4 all events", 4'd1, 32'h13E0);
    wr(4'd1, 32'h0A0);
    rd_chk("R5 partial clear", 4'd1, 32'h1340);
    wr(4'd1, 32'h1FFF);

    // R6: set beats clear
    @(negedge clk);
    bus_addr = 4'd1; bus_wr = 1; bus_wdata = 32'h1FFF; ev_par = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0; ev_par = 0;
    rd_chk("R6 set wins", 4'd1, 32'h080);
    wr(4'd1, 32'h1FFF);

    // R7 R8 R9
    wr(4'd3, 32'h00F0);
    rd_chk("R7 set mask", 4'd2, 32'h00F0);
    wr(4'd3, 32'hFFFF_1001);
    rd_chk("R7 or into mask", 4'd2, 32'h10F1);
    wr(4'd4, 32'h0030);
    rd_chk("R8 clear mask", 4'd2, 32'h10C1);
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R9 direct mask write ignored", 4'd2, 32'h10C1);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R9 live write ignored", 4'd0, 0);
    rd_chk("R9 set port reads zero", 4'd3, 0);
    rd_chk("R9 clear port reads zero", 4'd4, 0);

    // R10
    @(negedge clk); #1 chk("R10 idle irq low", {31'd0, irq}, 0);
    pulse(5);
    #1 chk("R10 enabled event raises irq", {31'd0, irq}, 1);
    wr(4'd1, 32'h1000);
    #1 chk("R10 clear drops irq", {31'd0, irq}, 0);
    pulse(4);
    #1 chk("R10 masked event no irq", {31'd0, irq}, 0);
    wr(4'd3, 32'h0200);
    #1 chk("R10 enabling pending bit raises irq", {31'd0, irq}, 1);
    wr(4'd4, 32'h0200);
    #1 chk("R10 disabling drops irq", {31'd0, irq}, 0);

    finish_run();
  end
endmodule